// File: doc/BRIEF.md
# Serial Compare-and-Swap Element

This block takes two unsigned words that arrive one bit per beat, most significant bit first, and sends both of them out again on two serial outputs. The smaller word always leaves on the low output and the larger one on the high output. Operands are compared while they stream. While the two incoming bits agree, both outputs carry that shared bit. At the first beat where they differ, the operand that shows a 0 is bound to the low output for the rest of the word. A start flag travels with the first bit of each word. The spacing between start flags sets the word length, so one instance handles 32-bit words, 8-bit words or 1-bit words with no change. The start flag leaves the block together with the data, so one element can feed the next in a chain of a sorting network.

Beats flow through a valid/ready handshake on both sides. A beat is taken when `in_valid` and `in_ready` are both high at a clock edge. A beat leaves when `out_valid` and `out_ready` are both high. `in_ready` drops only while the output holds a beat that the consumer refuses. During a stall the whole pipeline freezes, and the output beat stays constant until it is taken. Beats with `in_valid` low are bubbles: they move down the pipe but they affect neither the routing decision nor the data. After the first beat of a continuous stream, the pipeline delay of `LATENCY` edges is paid only once, and the stream then continues at one beat per clock.

Top module: `sorter_cas`

## Requirements
- R1: While reset is asserted and on the first edge after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: For two unsigned words of different value, every bit of the smaller word appears on `out_lo` and every bit of the larger word appears on `out_hi`, in the order the bits were taken.
- R3: Bits taken before the first beat at which the operands differ appear unchanged on both `out_lo` and `out_hi`.
- R4: Two equal words appear bit for bit on both outputs.
- R5: An input beat with `in_start` = 1 clears the routing decision of the previous word. Word length is the number of beats between start flags and may be as short as 1.
- R6: `out_start` is 1 exactly on the output beat that carries the first bit of a word.
- R7: With `out_ready` held high, a beat taken at clock edge E is taken at the output at edge E + `LATENCY`.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_start`, `out_hi` and `out_lo` hold their values on the next edge. No beat is lost or duplicated.
- R9: Cycles with `in_valid` = 0 inserted between the beats of a word do not change the routing or the output bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input beat is present |
| in_ready | output | 1 | Block can take an input beat |
| in_start | input | 1 | This beat is the first bit of a word |
| in_a | input | 1 | Bit of operand A |
| in_b | input | 1 | Bit of operand B |
| out_valid | output | 1 | An output beat is present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_start | output | 1 | Output beat is the first bit of a word |
| out_hi | output | 1 | Bit of the larger word |
| out_lo | output | 1 | Bit of the smaller word |

## Verification
The bench builds the block with `LATENCY` = 6 and streams words of 32, 8, 3 and 1 bits. This exercises mid-word locking at the most and least significant positions, words that restart one beat after a lock, and words whose comparison never resolves. Idle gaps inside words and a pseudo-random `out_ready` stall the six-stage pipe in every position. This checks that the decision state is not advanced by bubbles and that the frozen output is held.

// File: rtl/sorter_cas_pkg.sv
`timescale 1ns/1ps
package sorter_cas_pkg;

  // which operand has been bound to the low output for the current word
  typedef enum logic [1:0] {
    LK_OPEN  = 2'd0,
    LK_A_LOW = 2'd1,
    LK_B_LOW = 2'd2
  } lock_e;

  typedef struct packed {
    logic start;
    logic hi;
    logic lo;
  } beat_t;

endpackage

// File: rtl/sorter_cas_decide.sv
`timescale 1ns/1ps
module sorter_cas_decide
  import sorter_cas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  start,
  input  logic  a,
  input  logic  b,
  output beat_t route
);

  lock_e lock_q;
  lock_e lock_now;
  lock_e lock_nx;

  always_comb begin
    lock_now    = start ? LK_OPEN : lock_q;
    lock_nx     = lock_now;
    route.start = start;
    route.hi    = a;
    route.lo    = b;
    case (lock_now)
      LK_A_LOW: begin
        route.hi = b;
        route.lo = a;
      end
      LK_B_LOW: begin
        route.hi = a;
        route.lo = b;
      end
      default: begin
        if (a != b) begin
          // the operand holding the 0 is the smaller one
          lock_nx  = a ? LK_B_LOW : LK_A_LOW;
          route.hi = 1'b1;
          route.lo = 1'b0;
        end else begin
          route.hi = a;
          route.lo = a;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= LK_OPEN;
    end else if (take) begin
      lock_q <= lock_nx;
    end
  end

endmodule

// File: rtl/sorter_cas_pipe.sv
`timescale 1ns/1ps
module sorter_cas_pipe
  import sorter_cas_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  in_vld,
  input  beat_t in_beat,
  output logic  out_vld,
  output beat_t out_beat
);

  localparam int LAST = DEPTH - 1;

  logic  vld_q [DEPTH];
  beat_t dat_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic  vld_d;
    beat_t dat_d;
    if (i == 0) begin : g_head
      assign vld_d = in_vld;
      assign dat_d = in_beat;
    end else begin : g_body
      assign vld_d = vld_q[i-1];
      assign dat_d = dat_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        dat_q[i] <= '0;
      end else if (adv) begin
        vld_q[i] <= vld_d;
        dat_q[i] <= vld_d ? dat_d : '0;
      end
    end
  end

  assign out_vld  = vld_q[LAST];
  assign out_beat = dat_q[LAST];

endmodule

// File: rtl/sorter_cas.sv
`timescale 1ns/1ps
module sorter_cas
  import sorter_cas_pkg::*;
#(
  parameter int LATENCY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_start,
  input  logic in_a,
  input  logic in_b,
  output logic out_valid,
  input  logic out_ready,
  output logic out_start,
  output logic out_hi,
  output logic out_lo
);

  localparam int STAGES = (LATENCY < 1) ? 1 : LATENCY;

  logic  adv;
  logic  take;
  logic  tail_vld;
  beat_t routed;
  beat_t tail;

  // the pipe moves as a whole unless the consumer refuses a present beat
  assign adv  = !tail_vld || out_ready;
  assign take = in_valid && adv;

  sorter_cas_decide u_decide (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .start (in_start),
    .a     (in_a),
    .b     (in_b),
    .route (routed)
  );

  sorter_cas_pipe #(
    .DEPTH (STAGES)
  ) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .in_vld   (in_valid),
    .in_beat  (routed),
    .out_vld  (tail_vld),
    .out_beat (tail)
  );

  assign in_ready  = adv;
  assign out_valid = tail_vld;
  assign out_start = tail.start;
  assign out_hi    = tail.hi;
  assign out_lo    = tail.lo;

endmodule

// File: rtl/sorter_cas_chk.sv
`timescale 1ns/1ps
module sorter_cas_chk #(
  parameter int LATENCY = 6
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_start,
  input logic out_hi,
  input logic out_lo
);

  localparam int CW = $clog2(LATENCY + 2) + 1;

  logic          in_fire;
  logic          out_fire;
  logic [CW-1:0] inflight;
  logic          diff_seen;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight  <= '0;
      diff_seen <= 1'b0;
    end else begin
      inflight <= inflight + CW'(in_fire) - CW'(out_fire);
      if (out_fire) begin
        diff_seen <= (!out_start && diff_seen) || (out_hi != out_lo);
      end
    end
  end

  // R8: a refused output beat stays unchanged
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_start)
                                   && $stable(out_hi) && $stable(out_lo)));

  // R2: at the first differing output bit of a word the low output shows 0
  a_r2_first_split: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && (out_start || !diff_seen) && (out_hi != out_lo))
      |-> (!out_lo && out_hi));

  // R7: never more beats inside than pipeline slots
  a_r7_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LATENCY));

  // R8: no output beat without a matching input beat
  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> (inflight != '0));

endmodule

bind sorter_cas sorter_cas_chk #(.LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_start (out_start),
  .out_hi    (out_hi),
  .out_lo    (out_lo)
);

// File: tb/sorter_cas_test.sv
`timescale 1ns/1ps
module sorter_cas_test;

  localparam int LAT = 6;

  typedef struct {
    bit    st;
    bit    hi;
    bit    lo;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_start = 1'b0;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_start, out_hi, out_lo;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   gap = 0;
  bit   bp_mode = 1'b0;
  bit   lat_arm = 1'b0;
  bit   fire_arm = 1'b0;
  int   acc_cyc = 0;
  int   fire_cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] rnd = 32'h1234_5678;
  exp_t q[$];

  sorter_cas #(.LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_start(out_start), .out_hi(out_hi), .out_lo(out_lo)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // consumer back-pressure
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor / scoreboard
  bit prev_stall = 1'b0;
  bit p_st, p_hi, p_lo;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid === 1'b1 && out_start === p_st && out_hi === p_hi && out_lo === p_lo,
              "R8 hold", {out_valid, out_start, out_hi, out_lo}, {1'b1, p_st, p_hi, p_lo});
      end
      prev_stall = out_valid && !out_ready;
      p_st = out_start; p_hi = out_hi; p_lo = out_lo;
      if (out_valid && out_ready) begin
        if (fire_arm) begin
          fire_cyc = cyc + 1;
          fire_arm = 1'b0;
        end
        if (q.size() == 0) begin
          check(1'b0, "R8 extra beat", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_hi === e.hi && out_lo === e.lo, e.tag, {out_hi, out_lo}, {e.hi, e.lo});
          check(out_start === e.st, "R6", out_start, e.st);
        end
      end
    end
  end

  task automatic beat(input bit s, input bit a, input bit b);
    bit ok;
    in_valid = 1'b1; in_start = s; in_a = a; in_b = b;
    forever begin
      @(negedge clk);
      ok = in_ready;
      if (ok && lat_arm) begin
        acc_cyc = cyc + 1;
        lat_arm = 1'b0;
        fire_arm = 1'b1;
      end
      @(posedge clk); #1;
      if (ok) break;
    end
    in_valid = 1'b0; in_start = 1'b0;
    for (int g = 0; g < gap; g++) begin
      in_a = ~in_a; in_b = ~in_b; // junk on idle beats
      @(posedge clk); #1;
    end
  endtask

  task automatic send_word(input logic [31:0] a, input logic [31:0] b,
                           input int w, input string tag);
    logic [31:0] m, am, bm, big, sml;
    m   = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    am  = a & m;
    bm  = b & m;
    big = (am > bm) ? am : bm;
    sml = (am > bm) ? bm : am;
    for (int i = w - 1; i >= 0; i--) begin
      exp_t e;
      e.st = (i == w - 1); e.hi = big[i]; e.lo = sml[i]; e.tag = tag;
      q.push_back(e);
      beat(i == w - 1, am[i], bm[i]);
    end
  endtask

  function automatic logic [31:0] next_rnd(input logic [31:0] v);
    logic [31:0] x;
    x = v;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic drain();
    int n;
    n = 0;
    while ((q.size() != 0 || out_valid) && n < 2000) begin
      @(posedge clk); #1; n++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid in reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 ready in reset", in_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid after reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // R2: ordering in both directions and extremes
    send_word(32'h0000_0005, 32'h0000_0009, 32, "R2");
    send_word(32'hF000_0000, 32'h0FFF_FFFF, 32, "R2");
    send_word(32'h0000_0000, 32'hFFFF_FFFF, 32, "R2");
    send_word(32'hFFFF_FFFF, 32'h0000_0000, 32, "R2");
    for (int k = 0; k < 6; k++) begin
      logic [31:0] x, y;
      rnd = next_rnd(rnd); x = rnd;
      rnd = next_rnd(rnd); y = rnd;
      send_word(x, y, 32, "R2");
    end

    // R3: long common prefix, split late
    send_word(32'hABCD_1234, 32'hABCD_1235, 32, "R3");
    send_word(32'h8000_0001, 32'h8000_0000, 32, "R3");
    send_word(32'h7FFF_FF00, 32'h7FFF_FE00, 32, "R3");

    // R4: equal words
    send_word(32'hDEAD_BEEF, 32'hDEAD_BEEF, 32, "R4");
    send_word(32'h0000_0000, 32'h0000_0000, 32, "R4");

    // R5: restarts at short word lengths, alternating order
    send_word(32'h0F, 32'hF0, 8, "R5");
    send_word(32'hF0, 32'h0F, 8, "R5");
    send_word(32'h5, 32'h2, 3, "R5");
    send_word(32'h2, 32'h5, 3, "R5");
    send_word(32'h1, 32'h0, 1, "R5");
    send_word(32'h0, 32'h1, 1, "R5");
    send_word(32'h1, 32'h1, 1, "R5");
    send_word(32'h1, 32'h0, 1, "R5");

    // R9: idle cycles between beats
    gap = 2;
    send_word(32'h1357_9BDF, 32'h1357_0000, 32, "R9");
    send_word(32'h0000_00A0, 32'h0000_00A1, 32, "R9");
    gap = 0;

    // R7: pipeline delay
    drain();
    lat_arm = 1'b1;
    send_word(32'h9, 32'h6, 4, "R7");
    drain();
    check(fire_cyc - acc_cyc == LAT, "R7 latency", fire_cyc - acc_cyc, LAT);

    // R8: back-pressure with random values and lengths
    bp_mode = 1'b1;
    for (int k = 0; k < 12; k++) begin
      logic [31:0] x, y;
      rnd = next_rnd(rnd); x = rnd;
      rnd = next_rnd(rnd); y = (k % 3 == 0) ? x ^ 32'h1 : rnd;
      gap = k % 2;
      send_word(x, y, (k % 4 == 0) ? 5 : 32, "R8");
    end
    gap = 0;
    bp_mode = 1'b0;
    drain();
    check(q.size() == 0, "R8 lost beats", q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule